// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table held in memory. A request carries a 40-bit virtual page number and a table base address. The walker hashes the page number to a group of eight page table entries and reads those entries one at a time, in slot order, through a single memory read port. It compares each entry against the request. If no entry in this first group matches, it computes a second group index and searches that group the same way. The first matching entry ends the search and returns its physical page number and protection bits. If all sixteen entries fail to match, the walker reports that software must handle the miss.

The walker accepts one request at a time. It keeps at most one memory read in flight and waits for each read to return, however long the memory takes. The table occupies `2^(GRP_W+3)` entries starting at the base, so `GRP_W` sets the table size to suit the physical memory size.

Top module: `hpt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The first group index is `vpn[GRP_W-1:0] ^ vpn[2*GRP_W-1:GRP_W]`. The read address for slot s of group g is `base + g*8 + s`, in entry units.
- R3: Within a group, slots are read in the order 0 to 7. A new read is issued only after the previous one has returned.
- R4: An entry is laid out from the MSB down as valid (1 bit), hash-select (1 bit), tag (`VPN_W-GRP_W` bits, equal to `vpn[VPN_W-1:GRP_W]`), physical page number (`PPN_W` bits), and protection (`PROT_W` bits, at the LSBs). It matches only when valid is 1, the tag is equal, and hash-select equals 0 in the first group or 1 in the second group.
- R5: The search stops at the first matching entry and issues no further reads. The walker then raises `rsp_valid` with `rsp_hit`=1 and `rsp_trap`=0, and returns that entry's page number and protection bits.
- R6: After eight misses in the first group, the second group index is the bitwise complement of the first. It is read in the same slot order.
- R7: After sixteen misses, `rsp_valid` rises with `rsp_trap`=1, `rsp_hit`=0, and zero page number and protection.
- R8: An entry whose tag matches is not a match if it is invalid or if its hash-select bit names the other group.
- R9: `req_ready` is low from acceptance until the response. A request presented during that time is ignored and does not change the read sequence.
- R10: `rsp_valid` lasts exactly one cycle. `req_ready` is 1 again in the same cycle, so a new request can be accepted right away.
- R11: The walker works with any read latency of one cycle or more. It waits for `mem_rd_valid` before it evaluates an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_base | input | ADDR_W | Table base address, in entry units |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | ADDR_W | Entry address to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | PTE_W | Returned page table entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_trap | output | 1 | Both groups missed, software must handle it |
| rsp_ppn | output | PPN_W | Physical page number of the matching entry |
| rsp_prot | output | PROT_W | Protection bits of the matching entry |

## Verification
The bench builds the walker with `GRP_W`=4, a 20-bit page number and 4 protection bits. The table then has sixteen groups of eight entries, which fit in a small bench memory at two different base addresses. This small hash range lets the bench place decoy entries in both the first group and its complemented partner. It covers hits at the first slot, at a middle slot, in the second group and at the very last slot, as well as a full miss. A bench memory whose latency can be set from one to three cycles checks every issued address against a behavioural model, cycle by cycle.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int unsigned SLOT_W     = 3;
  localparam int unsigned GROUP_SIZE = 1 << SLOT_W;

  typedef enum logic {
    WLK_IDLE,
    WLK_WAIT
  } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int unsigned GRP_W = 10
) (
  input  logic [2*GRP_W-1:0] vpn_lo,
  input  logic               second,
  output logic [GRP_W-1:0]   grp_idx
);
  logic [GRP_W-1:0] fold;

  always_comb begin
    fold    = vpn_lo[GRP_W-1:0] ^ vpn_lo[2*GRP_W-1:GRP_W];
    grp_idx = second ? ~fold : fold;
  end
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned GRP_W  = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [GRP_W-1:0]  grp_idx,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned OFS_W = GRP_W + SLOT_W;

  generate
    if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("hpt_addr_gen: ADDR_W too small for table");
    end
  endgenerate

  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs  = {grp_idx, slot};
    addr = base + ADDR_W'(ofs);
  end
endmodule

// File: rtl/hpt_pte_check.sv
module hpt_pte_check #(
  parameter int unsigned TAG_W  = 30,
  parameter int unsigned PPN_W  = 28,
  parameter int unsigned PROT_W = 4,
  parameter int unsigned PTE_W  = 2 + TAG_W + PPN_W + PROT_W
) (
  input  logic [PTE_W-1:0]  pte,
  input  logic [TAG_W-1:0]  tag_ref,
  input  logic              second,
  output logic              match,
  output logic [PPN_W-1:0]  ppn,
  output logic [PROT_W-1:0] prot
);
  localparam int unsigned PPN_LO = PROT_W;
  localparam int unsigned TAG_LO = PROT_W + PPN_W;
  localparam int unsigned HSEL_B = TAG_LO + TAG_W;
  localparam int unsigned VLD_B  = HSEL_B + 1;

  generate
    if (PTE_W != VLD_B + 1) begin : g_bad_pte
      $error("hpt_pte_check: PTE_W does not fit the field layout");
    end
  endgenerate

  logic             vld;
  logic             hsel;
  logic [TAG_W-1:0] tag;

  always_comb begin
    vld   = pte[VLD_B];
    hsel  = pte[HSEL_B];
    tag   = pte[TAG_LO +: TAG_W];
    ppn   = pte[PPN_LO +: PPN_W];
    prot  = pte[0 +: PROT_W];
    match = vld && (hsel == second) && (tag == tag_ref);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int unsigned VPN_W  = 40,
  parameter int unsigned GRP_W  = 10,
  parameter int unsigned PPN_W  = 28,
  parameter int unsigned PROT_W = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTE_W  = 2 + (VPN_W - GRP_W) + PPN_W + PROT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ADDR_W-1:0] req_base,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_trap,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PROT_W-1:0] rsp_prot
);
  localparam int unsigned TAG_W     = VPN_W - GRP_W;
  localparam int unsigned TBL_ENTRY = GROUP_SIZE << GRP_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SIZE - 1);

  generate
    if (2 * GRP_W > VPN_W) begin : g_bad_hash
      $error("hpt_walker: hash needs 2*GRP_W <= VPN_W");
    end
    if (TBL_ENTRY < PPN_W) begin : g_bad_size
      $error("hpt_walker: table smaller than the physical page number width");
    end
  endgenerate

  walk_state_t       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic              pass_q;
  logic [SLOT_W-1:0] slot_q;

  logic              accept;
  logic              last_entry;
  logic              nxt_pass;
  logic [SLOT_W-1:0] nxt_slot;
  logic [VPN_W-1:0]  vpn_sel;
  logic [ADDR_W-1:0] base_sel;
  logic [GRP_W-1:0]  nxt_idx;
  logic [ADDR_W-1:0] nxt_addr;
  logic              ent_match;
  logic [PPN_W-1:0]  ent_ppn;
  logic [PROT_W-1:0] ent_prot;

  assign req_ready  = (state_q == WLK_IDLE);
  assign accept     = req_ready && req_valid;
  assign last_entry = pass_q && (slot_q == LAST_SLOT);

  always_comb begin
    if (accept) begin
      nxt_pass = 1'b0;
      nxt_slot = '0;
      vpn_sel  = req_vpn;
      base_sel = req_base;
    end else begin
      nxt_pass = pass_q | (slot_q == LAST_SLOT);
      nxt_slot = slot_q + SLOT_W'(1);
      vpn_sel  = vpn_q;
      base_sel = base_q;
    end
  end

  hpt_hash #(
    .GRP_W (GRP_W)
  ) i_hash (
    .vpn_lo  (vpn_sel[2*GRP_W-1:0]),
    .second  (nxt_pass),
    .grp_idx (nxt_idx)
  );

  hpt_addr_gen #(
    .ADDR_W (ADDR_W),
    .GRP_W  (GRP_W)
  ) i_addr (
    .base    (base_sel),
    .grp_idx (nxt_idx),
    .slot    (nxt_slot),
    .addr    (nxt_addr)
  );

  hpt_pte_check #(
    .TAG_W  (TAG_W),
    .PPN_W  (PPN_W),
    .PROT_W (PROT_W),
    .PTE_W  (PTE_W)
  ) i_check (
    .pte     (mem_rd_data),
    .tag_ref (vpn_q[VPN_W-1:GRP_W]),
    .second  (pass_q),
    .match   (ent_match),
    .ppn     (ent_ppn),
    .prot    (ent_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WLK_IDLE;
      vpn_q       <= '0;
      base_q      <= '0;
      pass_q      <= 1'b0;
      slot_q      <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_trap    <= 1'b0;
      rsp_ppn     <= '0;
      rsp_prot    <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rsp_valid <= 1'b0;
      case (state_q)
        WLK_IDLE: begin
          if (req_valid) begin
            vpn_q       <= req_vpn;
            base_q      <= req_base;
            pass_q      <= nxt_pass;
            slot_q      <= nxt_slot;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= nxt_addr;
            state_q     <= WLK_WAIT;
          end
        end
        WLK_WAIT: begin
          if (mem_rd_valid) begin
            if (ent_match) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
              rsp_trap  <= 1'b0;
              rsp_ppn   <= ent_ppn;
              rsp_prot  <= ent_prot;
              state_q   <= WLK_IDLE;
            end else if (last_entry) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              rsp_trap  <= 1'b1;
              rsp_ppn   <= '0;
              rsp_prot  <= '0;
              state_q   <= WLK_IDLE;
            end else begin
              pass_q      <= nxt_pass;
              slot_q      <= nxt_slot;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= nxt_addr;
            end
          end
        end
        default: state_q <= WLK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic mem_rd_en,
  input logic mem_rd_valid,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_trap
);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  a_r9_no_read_when_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_en);

  a_r9_accept_starts_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_rd_en);

  a_r10_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r10_ready_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  a_r5_hit_xor_trap: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit ^ rsp_trap));

  a_r11_rsp_follows_data: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mem_rd_valid));
endmodule

bind hpt_walker hpt_walker_chk i_hpt_walker_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_valid (mem_rd_valid),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_trap     (rsp_trap)
);

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  localparam int VPN_W  = 40;
  localparam int GRP_W  = 4;
  localparam int PPN_W  = 20;
  localparam int PROT_W = 4;
  localparam int ADDR_W = 16;
  localparam int TAG_W  = VPN_W - GRP_W;
  localparam int PTE_W  = 2 + TAG_W + PPN_W + PROT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [VPN_W-1:0]  req_vpn = '0;
  logic [ADDR_W-1:0] req_base = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rd_valid;
  logic [PTE_W-1:0]  mem_rd_data;
  logic              rsp_valid;
  logic              rsp_hit;
  logic              rsp_trap;
  logic [PPN_W-1:0]  rsp_ppn;
  logic [PROT_W-1:0] rsp_prot;

  always #5 clk = ~clk;

  hpt_walker #(
    .VPN_W (VPN_W), .GRP_W (GRP_W), .PPN_W (PPN_W),
    .PROT_W(PROT_W), .ADDR_W(ADDR_W), .PTE_W (PTE_W)
  ) i_hpt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_base(req_base), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_trap(rsp_trap), .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot)
  );

  int n_checks = 0;
  int n_errors = 0;

  logic [PTE_W-1:0] mem [256];
  int               lat_cfg = 1;
  int               exp_q[$];
  bit               e_hit;
  logic [PPN_W-1:0] e_ppn;
  logic [PROT_W-1:0] e_prot;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [PTE_W-1:0] mk_pte(input bit v, input bit h,
      input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
      input logic [PROT_W-1:0] prot);
    logic [TAG_W-1:0] tag;
    tag = vpn[VPN_W-1:GRP_W];
    return {v, h, tag, ppn, prot};
  endfunction

  function automatic int grp_of(input logic [VPN_W-1:0] vpn, input bit second);
    logic [GRP_W-1:0] g;
    g = vpn[GRP_W-1:0] ^ vpn[2*GRP_W-1:GRP_W];
    if (second) g = ~g;
    return int'(g);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  // behavioural model of one search: expected address list and result
  task automatic model(input logic [VPN_W-1:0] vpn, input int base);
    exp_q.delete();
    e_hit = 0; e_ppn = '0; e_prot = '0;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        int a;
        logic [PTE_W-1:0] e;
        a = base + grp_of(vpn, p != 0) * 8 + s;
        exp_q.push_back(a);
        e = mem[a];
        if (e[PTE_W-1] && (e[PTE_W-2] == (p != 0)) &&
            (e[PTE_W-3 -: TAG_W] == vpn[VPN_W-1:GRP_W])) begin
          e_hit  = 1;
          e_ppn  = e[PROT_W +: PPN_W];
          e_prot = e[0 +: PROT_W];
          return;
        end
      end
    end
  endtask

  // memory responder and per-clock address monitor
  int               cnt = -1;
  bit               pending = 0;
  logic [ADDR_W-1:0] pend_addr = '0;
  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem[pend_addr[7:0]];
          cnt = -1;
          pending = 0;
        end
      end
      if (!rst && mem_rd_en) begin
        chk(!pending, "R3", "read issued while one outstanding", 64'(mem_rd_addr), 0);
        if (exp_q.size() == 0)
          chk(0, "R5", "read after search should have ended", 64'(mem_rd_addr), 0);
        else begin
          int ea;
          ea = exp_q.pop_front();
          chk(int'(mem_rd_addr) == ea, "R2/R3/R6", "read address", 64'(mem_rd_addr), 64'(ea));
        end
        pend_addr = mem_rd_addr;
        pending   = 1;
        cnt       = lat_cfg;
      end
    end
  end

  task automatic lookup(input logic [VPN_W-1:0] vpn, input int base,
                        input int lat, input bit poke, input string req);
    int  t;
    bit  got;
    lat_cfg = lat;
    model(vpn, base);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", {req, " ready before request"}, 64'(req_ready), 1);
    req_valid = 1'b1; req_vpn = vpn; req_base = ADDR_W'(base);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; got = 0;
    while (!got && t < 300) begin
      @(negedge clk);
      t++;
      if (poke && t == 2) begin
        req_valid = 1'b1; req_vpn = ~vpn; req_base = ADDR_W'(base + 3);
      end
      if (poke && t == 3) begin
        chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 0);
        req_valid = 1'b0;
      end
      if (rsp_valid) got = 1;
    end
    chk(got, req, "response seen", 64'(got), 1);
    chk(rsp_hit == e_hit, req, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
    chk(rsp_trap == !e_hit, "R7", "rsp_trap", 64'(rsp_trap), 64'(!e_hit));
    chk(rsp_ppn == e_ppn, req, "rsp_ppn", 64'(rsp_ppn), 64'(e_ppn));
    chk(rsp_prot == e_prot, req, "rsp_prot", 64'(rsp_prot), 64'(e_prot));
    chk(req_ready == 1'b1, "R10", "ready with response", 64'(req_ready), 1);
    chk(exp_q.size() == 0, "R5", "reads left unissued", 64'(exp_q.size()), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "response longer than one cycle", 64'(rsp_valid), 0);
    chk(mem_rd_en == 1'b0, "R5", "read after response", 64'(mem_rd_en), 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] va, vb, vc, vd;
    int b1, b2;
    b1 = 20; b2 = 100;
    va = 40'h12_3456_7A9C;   // first group 5, second group 10
    vb = 40'h00_0000_0133;   // first group 0, second group 15
    vc = 40'hFF_0000_00E1;   // first group 15, second group 0
    vd = 40'h0A_BCDE_F027;   // first group 5, second group 10
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 0);
    chk(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset", 64'(mem_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R4 R5: hit at slot 0 of the first group
    mem[b1 + grp_of(va, 0) * 8 + 0] = mk_pte(1, 0, va, 20'hABCDE, 4'h5);
    lookup(va, b1, 1, 0, "R5");

    // R8 R11: decoys before a hit at slot 5, two-cycle latency
    clear_mem();
    mem[b2 + grp_of(vb, 0) * 8 + 0] = mk_pte(1, 0, vb ^ 40'h10, 20'h11111, 4'h1);
    mem[b2 + grp_of(vb, 0) * 8 + 1] = mk_pte(0, 0, vb, 20'h22222, 4'h2);
    mem[b2 + grp_of(vb, 0) * 8 + 2] = mk_pte(1, 1, vb, 20'h33333, 4'h3);
    mem[b2 + grp_of(vb, 0) * 8 + 5] = mk_pte(1, 0, vb, 20'h12345, 4'h9);
    mem[b2 + grp_of(vb, 0) * 8 + 6] = mk_pte(1, 0, vb, 20'h66666, 4'h6);
    lookup(vb, b2, 2, 0, "R8");

    // R6 R9: full first-group miss, hit in the second group, busy request ignored
    clear_mem();
    for (int s = 0; s < 8; s++)
      mem[b1 + grp_of(vc, 0) * 8 + s] = mk_pte(1, 0, vc ^ 40'h100, 20'h00F00 + s, 4'h0);
    mem[b1 + grp_of(vc, 1) * 8 + 2] = mk_pte(1, 1, vc, 20'hBEEF1, 4'hC);
    lookup(vc, b1, 2, 1, "R6");

    // R7 R8: full miss with wrong-group and invalid decoys, three-cycle latency
    clear_mem();
    mem[b2 + grp_of(vd, 0) * 8 + 4] = mk_pte(1, 1, vd, 20'h44444, 4'h4);
    mem[b2 + grp_of(vd, 1) * 8 + 6] = mk_pte(1, 0, vd, 20'h55555, 4'h5);
    mem[b2 + grp_of(vd, 1) * 8 + 7] = mk_pte(0, 1, vd, 20'h77777, 4'h7);
    lookup(vd, b2, 3, 0, "R7");

    // R10 R6: back-to-back request, hit at the last slot of the second group
    clear_mem();
    mem[b1 + grp_of(va, 1) * 8 + 7] = mk_pte(1, 1, va, 20'hFEDCB, 4'hA);
    lookup(va, b1, 1, 0, "R6");
    lookup(va, b1, 3, 0, "R11");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule